// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a bank of asynchronous event lines and turns their level changes into interrupt activity for the processor. Each line is brought into the clock domain through a two-flop synchronizer. A detected transition is compared against two per-line selectors, one for rising and one for falling, and a selected transition latches a sticky pending flag. Independently of the selectors, every transition on a line whose interrupt-enable bit is set produces a one-cycle pulse on that line's interrupt output.

Software controls the block through six 32-bit registers inside a 0x400-byte window on a simple single-cycle register bus. Pending flags are write-one-to-clear. The event-enable and software-event registers are held as plain storage for neighbouring logic. Only 23 lines exist, so register bits 31..23 always read as zero.

Top module: `xirq_edge_ctrl`

## Requirements
- R1: After reset every register reads 0x00000000 and `irq_pulse` is all zero.
- R2: The registers at offsets 0x00 (interrupt enable), 0x04 (event enable), 0x08 (rising select), 0x0C (falling select) and 0x10 (software event) return the last value written, with bits 31..23 reading 0.
- R3: A 0-to-1 transition on line n with bit n of the rising select set sets bit n of the pending register at offset 0x14.
- R4: A 1-to-0 transition on line n with bit n of the falling select set sets pending bit n.
- R5: Pending bits are set regardless of the interrupt-enable bit, and a transition whose direction is not selected leaves the pending bit unchanged.
- R6: Every transition on line n, selected or not, gives exactly one cycle of `irq_pulse[n]` high when interrupt-enable bit n is 1 in the cycle before the pulse. When that bit is 0, the line never pulses.
- R7: A write to offset 0x14 clears each pending bit written as 1 and leaves bits written as 0 unchanged.
- R8: When a pending clear and a new selected transition land on the same bit in the same clock edge, the bit ends up set.
- R9: Reads from any other offset, including misaligned offsets, return 0. Writes to them change no register.
- R10: A new input level that is first sampled at clock edge E appears in the pending register and on `irq_pulse` at the second edge after E, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 23 | Asynchronous event lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe, 0 otherwise |
| irq_pulse | output | 23 | Per-line one-cycle interrupt pulse |

## Verification
Two functions can fall on the same clock edge: a software write-one-to-clear of the pending register, and a hardware edge that sets the same bit. The bench provokes this with a directed sequence. It releases one line and raises another, waits two cycles for the synchronizer, and then issues the clear so that it commits on the edge where both hits register. A third bit that is only cleared shows that the clear itself still acts. A random phase of line flips and register writes also lands many such collisions, and each read is compared with a bench model in which a set overrides a clear.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  localparam int DATA_W = 32;

  localparam logic [15:0] OFF_IRQ_EN  = 16'h0000;
  localparam logic [15:0] OFF_EVT_EN  = 16'h0004;
  localparam logic [15:0] OFF_RISE    = 16'h0008;
  localparam logic [15:0] OFF_FALL    = 16'h000C;
  localparam logic [15:0] OFF_SW_EVT  = 16'h0010;
  localparam logic [15:0] OFF_PENDING = 16'h0014;

  // Plain storage registers come first so their index equals the enum value.
  typedef enum logic [2:0] {
    RS_IRQ_EN  = 3'd0,
    RS_EVT_EN  = 3'd1,
    RS_RISE    = 3'd2,
    RS_FALL    = 3'd3,
    RS_SW_EVT  = 3'd4,
    RS_PENDING = 3'd5,
    RS_NONE    = 3'd6
  } reg_sel_e;

  localparam int NUM_PLAIN = 5;

  function automatic reg_sel_e decode_off(input logic [15:0] off);
    case (off)
      OFF_IRQ_EN:  return RS_IRQ_EN;
      OFF_EVT_EN:  return RS_EVT_EN;
      OFF_RISE:    return RS_RISE;
      OFF_FALL:    return RS_FALL;
      OFF_SW_EVT:  return RS_SW_EVT;
      OFF_PENDING: return RS_PENDING;
      default:     return RS_NONE;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] line_mask(input int n);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Set dominates clear.
  function automatic logic [DATA_W-1:0] pend_update(input logic [DATA_W-1:0] cur,
                                                    input logic [DATA_W-1:0] clr,
                                                    input logic [DATA_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int NL     = 23,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] d,
  output logic [NL-1:0] q
);

  logic [NL-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/xirq_edge_detect.sv
module xirq_edge_detect #(
  parameter int NL = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] lvl,
  input  logic [NL-1:0] rise_sel,
  input  logic [NL-1:0] fall_sel,
  output logic [NL-1:0] change,
  output logic [NL-1:0] hit
);

  logic [NL-1:0] prev_q;
  logic [NL-1:0] rise;
  logic [NL-1:0] fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise   = lvl & ~prev_q;
  assign fall   = ~lvl & prev_q;
  assign change = lvl ^ prev_q;
  assign hit    = (rise & rise_sel) | (fall & fall_sel);

endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int NL     = 23,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NL-1:0]     edge_hit,
  output logic [NL-1:0]     irq_en,
  output logic [NL-1:0]     rise_sel,
  output logic [NL-1:0]     fall_sel,
  output logic [NL-1:0]     pend_lines,
  output logic [DATA_W-1:0] clr_word
);

  localparam logic [DATA_W-1:0] LMASK = line_mask(NL);

  reg_sel_e          sel;
  logic              wr_en;
  logic              rd_en;
  logic [DATA_W-1:0] wr_val;
  logic [DATA_W-1:0] hit_word;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] plain_q [NUM_PLAIN];
  logic [DATA_W-1:0] pend_q;

  assign sel      = decode_off(16'(bus_addr));
  assign wr_en    = bus_sel & bus_wr;
  assign rd_en    = bus_sel & ~bus_wr;
  assign wr_val   = bus_wdata & LMASK;
  assign hit_word = DATA_W'(edge_hit);
  assign clr_word = (wr_en && sel == RS_PENDING) ? wr_val : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PLAIN; i++) plain_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_PLAIN; i++) begin
        if (sel == reg_sel_e'(3'(i))) plain_q[i] <= wr_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_update(pend_q, clr_word, hit_word);
  end

  always_comb begin
    case (sel)
      RS_IRQ_EN:  rd_word = plain_q[0];
      RS_EVT_EN:  rd_word = plain_q[1];
      RS_RISE:    rd_word = plain_q[2];
      RS_FALL:    rd_word = plain_q[3];
      RS_SW_EVT:  rd_word = plain_q[4];
      RS_PENDING: rd_word = pend_q;
      default:    rd_word = '0;
    endcase
  end

  assign bus_rdata  = rd_en ? rd_word : '0;
  assign irq_en     = plain_q[0][NL-1:0];
  assign rise_sel   = plain_q[2][NL-1:0];
  assign fall_sel   = plain_q[3][NL-1:0];
  assign pend_lines = pend_q[NL-1:0];

endmodule

// File: rtl/xirq_edge_ctrl.sv
module xirq_edge_ctrl
  import xirq_pkg::*;
#(
  parameter int NUM_LINES   = 23,
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [NUM_LINES-1:0] irq_pulse
);

  // Named internal events, visible to the bound checker.
  logic [NUM_LINES-1:0] line_sync;
  logic [NUM_LINES-1:0] line_change;
  logic [NUM_LINES-1:0] edge_hit;
  logic [NUM_LINES-1:0] irq_en;
  logic [NUM_LINES-1:0] rise_sel;
  logic [NUM_LINES-1:0] fall_sel;
  logic [NUM_LINES-1:0] pend_lines;
  logic [DATA_W-1:0]    clr_word;
  logic [NUM_LINES-1:0] irq_q;

  xirq_sync #(.NL(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (line_in),
    .q     (line_sync)
  );

  xirq_edge_detect #(.NL(NUM_LINES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (line_sync),
    .rise_sel (rise_sel),
    .fall_sel (fall_sel),
    .change   (line_change),
    .hit      (edge_hit)
  );

  xirq_regs #(.NL(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .edge_hit   (edge_hit),
    .irq_en     (irq_en),
    .rise_sel   (rise_sel),
    .fall_sel   (fall_sel),
    .pend_lines (pend_lines),
    .clr_word   (clr_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= line_change & irq_en;
  end

  assign irq_pulse = irq_q;

endmodule

// File: rtl/xirq_edge_ctrl_checker.sv
module xirq_edge_ctrl_checker
  import xirq_pkg::*;
#(
  parameter int NL = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NL-1:0]     irq_pulse,
  input logic [NL-1:0]     irq_en,
  input logic [NL-1:0]     line_change,
  input logic [NL-1:0]     edge_hit,
  input logic [NL-1:0]     pend_lines,
  input logic [DATA_W-1:0] clr_word,
  input logic [DATA_W-1:0] bus_rdata
);

  localparam logic [DATA_W-1:0] HI_MASK = ~line_mask(NL);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> irq_pulse == '0);

  assert_hi_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & HI_MASK) == '0);

  assert_pend_needs_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit == '0 |=> (pend_lines & ~$past(pend_lines)) == '0);

  assert_pulse_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse & ~$past(irq_en)) == '0);

  assert_pulse_after_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse & ~$past(line_change)) == '0);

  assert_clear_only_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_word == '0 |=> ($past(pend_lines) & ~pend_lines) == '0);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit != '0 |=> (pend_lines & $past(edge_hit)) == $past(edge_hit));

endmodule

bind xirq_edge_ctrl xirq_edge_ctrl_checker #(.NL(NUM_LINES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_pulse   (irq_pulse),
  .irq_en      (irq_en),
  .line_change (line_change),
  .edge_hit    (edge_hit),
  .pend_lines  (pend_lines),
  .clr_word    (clr_word),
  .bus_rdata   (bus_rdata)
);

// File: tb/xirq_edge_ctrl_bench.sv
`timescale 1ns/1ps
module xirq_edge_ctrl_bench;

  localparam int NL = 23;
  localparam logic [31:0] LM = 32'h007F_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] line_in = '0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [9:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] irq_pulse;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  xirq_edge_ctrl u_xirq_edge_ctrl (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pulse(irq_pulse)
  );

  // Bench model of the requirements.
  logic [NL-1:0] m_s1, m_s2, m_prev;
  logic [NL-1:0] m_ien, m_een, m_rise, m_fall, m_swe, m_pend;
  logic [NL-1:0] exp_pulse;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0;
      m_ien = '0; m_een = '0; m_rise = '0; m_fall = '0; m_swe = '0; m_pend = '0;
      exp_pulse = '0;
    end else begin : model_step
      logic [NL-1:0] chg, hit, clr, wv;
      chg = m_s2 ^ m_prev;
      hit = (chg & m_s2 & m_rise) | (chg & ~m_s2 & m_fall);
      wv  = bus_wdata[NL-1:0];
      clr = (bus_sel && bus_wr && bus_addr == 10'h014) ? wv : '0;
      exp_pulse = chg & m_ien;
      m_pend = (m_pend & ~clr) | hit;
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          10'h000: m_ien  = wv;
          10'h004: m_een  = wv;
          10'h008: m_rise = wv;
          10'h00C: m_fall = wv;
          10'h010: m_swe  = wv;
          default: ;
        endcase
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = line_in;
    end
  end

  function automatic logic [31:0] exp_read(input logic [9:0] a);
    case (a)
      10'h000: return 32'(m_ien);
      10'h004: return 32'(m_een);
      10'h008: return 32'(m_rise);
      10'h00C: return 32'(m_fall);
      10'h010: return 32'(m_swe);
      10'h014: return 32'(m_pend);
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [9:0] pick_off(input int k);
    case (k)
      0: return 10'h000;
      1: return 10'h004;
      2: return 10'h008;
      3: return 10'h00C;
      4: return 10'h010;
      5: return 10'h014;
      6: return 10'h018;
      7: return 10'h015;
      default: return 10'($urandom % 1024);
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock; check the interrupt output against the model (R6).
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    chk(irq_pulse == exp_pulse, "R6 pulse vs model", 32'(irq_pulse), 32'(exp_pulse));
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    for (int k = 0; k < 6; k++) rd(pick_off(k), 32'h0, "R1 reset value");
    chk(irq_pulse == '0, "R1 irq idle", 32'(irq_pulse), 32'h0);

    // R2: storage registers, upper bits read 0
    for (int k = 0; k < 5; k++) begin
      wr(pick_off(k), 32'hFFFF_FFFF);
      rd(pick_off(k), LM, "R2 all ones masked");
    end
    for (int k = 0; k < 5; k++) begin
      wr(pick_off(k), 32'hA5A5_0000 | 32'(k * 32'h111));
      rd(pick_off(k), (32'hA5A5_0000 | 32'(k * 32'h111)) & LM, "R2 pattern");
    end
    for (int k = 0; k < 5; k++) wr(pick_off(k), 32'h0);

    // R3, R5, R10: rising edge on line 3, interrupt disabled
    wr(10'h008, 32'h0000_0008);
    line_in[3] = 1'b1;
    idle(2);
    rd(10'h014, 32'h0, "R10 not before second edge");
    idle(1);
    rd(10'h014, 32'h0000_0008, "R3 R10 rising sets pending while disabled R5");

    // R5: unselected direction leaves pending alone
    line_in[4] = 1'b1;
    idle(4);
    rd(10'h014, 32'h0000_0008, "R5 unselected edge");

    // R7: write-one-to-clear
    wr(10'h014, 32'h0);
    rd(10'h014, 32'h0000_0008, "R7 zero write keeps");
    wr(10'h014, 32'h0000_0008);
    rd(10'h014, 32'h0, "R7 one write clears");

    // R4: falling edge
    wr(10'h00C, 32'h0000_0008);
    line_in[3] = 1'b0;
    idle(3);
    rd(10'h014, 32'h0000_0008, "R4 falling sets pending");
    wr(10'h014, 32'hFFFF_FFFF);
    wr(10'h00C, 32'h0);
    wr(10'h008, 32'h0);

    // R6: pulse on enabled line, none on disabled line
    wr(10'h000, 32'h0000_0004);
    line_in[2] = 1'b1;
    idle(2);
    chk(irq_pulse == '0, "R6 no early pulse", 32'(irq_pulse), 32'h0);
    idle(1);
    chk(irq_pulse == 23'h4, "R6 pulse high", 32'(irq_pulse), 32'h4);
    idle(1);
    chk(irq_pulse == '0, "R6 one cycle", 32'(irq_pulse), 32'h0);
    rd(10'h014, 32'h0, "R5 pulse without select leaves pending");
    wr(10'h000, 32'h0);
    line_in[2] = 1'b0;
    for (int i = 0; i < 4; i++) begin
      cyc();
      chk(irq_pulse == '0, "R6 disabled line quiet", 32'(irq_pulse), 32'h0);
    end

    // R8: clear and set on the same edge
    wr(10'h008, 32'h0000_00E0);
    wr(10'h00C, 32'h0000_0060);
    line_in[5] = 1'b1; line_in[7] = 1'b1;
    idle(4);
    rd(10'h014, 32'h0000_00A0, "R8 setup");
    line_in[5] = 1'b0; line_in[6] = 1'b1;
    idle(2);
    wr(10'h014, 32'h0000_00E0);
    rd(10'h014, 32'h0000_0060, "R8 set wins, bit7 cleared");

    // R9: unmapped offsets
    wr(10'h018, 32'hFFFF_FFFF);
    wr(10'h3FC, 32'hFFFF_FFFF);
    wr(10'h001, 32'hFFFF_FFFF);
    wr(10'h015, 32'hFFFF_FFFF);
    rd(10'h018, 32'h0, "R9 unmapped read");
    rd(10'h3FC, 32'h0, "R9 unmapped read top");
    rd(10'h001, 32'h0, "R9 misaligned read");
    for (int k = 0; k < 6; k++) rd(pick_off(k), exp_read(pick_off(k)), "R9 no side effect");
    rd(10'h014, 32'h0000_0060, "R9 pending untouched");

    // Random phase
    for (int it = 0; it < 4000; it++) begin
      int op;
      logic [9:0] a;
      line_in = line_in ^ NL'($urandom & $urandom & $urandom);
      op = int'($urandom % 8);
      a  = pick_off(int'($urandom % 9));
      if (op < 3) begin
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = $urandom;
      end else if (op < 5) begin
        rd(a, exp_read(a), "R2 R3 R4 R7 R8 R9 random read");
      end
      cyc();
      bus_sel = 1'b0; bus_wr = 1'b0;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule